// File: doc/BRIEF.md
# Edge-Triggered External Line Interrupt and Wakeup Controller

This block watches a bank of external input lines and turns chosen transitions on them into interrupt and wakeup requests. Every line first passes through a two-stage synchroniser. It can then be routed, line by line, through a digital glitch filter. That filter accepts a new level only after the line has held it for a set number of clock cycles. A per-line edge detector then qualifies the line. It uses two masks of its own: one arms rising transitions and the other arms falling transitions. Clearing both masks for a line silences that line completely.

Each qualified edge sets a sticky flag for its line. Software clears the flag by writing a 1 to its bit in the flag register. If a fresh edge arrives in the same cycle as that clear, the edge wins and the event is kept. The flags feed two independent gates. The interrupt gate ANDs them with an interrupt mask and ORs them into three grouped requests of unequal width: lines 7..0, lines 15..8 and lines 17..16. The wakeup gate ANDs them with a wakeup mask and ORs all lines into one request. Within a group every line has the same standing, and software decides which flags to serve.

The glitch filter runs as a four-state machine per line. FLT_LOW and FLT_HIGH are the settled states. FLT_RISE_CHK and FLT_FALL_CHK are the checking states. From FLT_LOW, a 1 at the input moves to FLT_RISE_CHK. In FLT_RISE_CHK a 0 at the input returns to FLT_LOW, and the required run of 1s moves on to FLT_HIGH. From FLT_HIGH, a 0 at the input moves to FLT_FALL_CHK. In FLT_FALL_CHK a 1 at the input returns to FLT_HIGH, and the required run of 0s moves on to FLT_LOW. The filtered level is high in FLT_HIGH and in FLT_FALL_CHK.

Top module: `exti_ctrl`

## Requirements
- R1: A line whose rising mask bit (register 3) is set and whose falling mask bit (register 4) is clear sets its flag on a 0-to-1 transition, and not on a 1-to-0 transition.
- R2: A line whose falling mask bit is set and whose rising mask bit is clear sets its flag on a 1-to-0 transition, and not on a 0-to-1 transition.
- R3: A line with both mask bits set sets its flag on either transition.
- R4: A line with both mask bits clear never sets its flag. Interrupt and wakeup enables make no difference to this, so such a line raises no interrupt and no wakeup.
- R5: A flag stays set until software clears it, whatever the line does afterwards.
- R6: The flag register is at address 0 and clears on a write of 1. A written 1 clears that bit only. A written 0 leaves that bit unchanged.
- R7: If a qualified edge occurs in the same cycle as a write of 1 to that line's flag, the flag is set after that cycle.
- R8: irq_o[0] is the OR of flag AND interrupt enable (register 1) over lines 7..0. irq_o[1] covers lines 15..8 and irq_o[2] covers lines 17..16. An interrupt request falls only after a bus write.
- R9: wake_o is the OR of flag AND wakeup enable (register 2) over all 18 lines. It falls only after a bus write.
- R10: With the filter enable bit (register 5) set, a pulse held for fewer than 3 clock cycles sets no flag, and a level held for at least 3 cycles is accepted. With the bit clear, a 1-cycle pulse is seen as two edges.
- R11: Registers 0 to 5 are each 18 bits wide, reset to 0 and read back as written. Register 0 reads back as the current flags. Addresses 6 and 7 read as 0 and ignore writes. Read data appears on bus_rdata_o one cycle after bus_rd_i.
- R12: After reset, all flags, irq_o and wake_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 18 | External lines, asynchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 18 | Write data |
| bus_rdata_o | output | 18 | Read data, registered |
| irq_o | output | 3 | Grouped interrupt requests (bit 0: lines 7..0, bit 1: 15..8, bit 2: 17..16) |
| wake_o | output | 1 | Wakeup request |

## Verification
The hardest case to reach from the ports is an edge that qualifies in exactly the cycle when a clear write for the same line is captured. To reach it, the bench counts the synchroniser latency: it moves an unfiltered line and places the write-1 strobe on the second clock edge after the change. The short pulses that the filter must reject are equally delicate. The bench therefore drives them on the falling clock edge with widths of exactly one and two cycles. It then mixes those with long holds across random mask settings.

// File: rtl/exti_pkg.sv
package exti_pkg;

    // Word addresses of the register bank; the flag register must stay at 0.
    typedef enum logic [2:0] {
        REG_FLAG    = 3'd0,
        REG_IRQ_EN  = 3'd1,
        REG_WAKE_EN = 3'd2,
        REG_RISE_EN = 3'd3,
        REG_FALL_EN = 3'd4,
        REG_FILT_EN = 3'd5
    } reg_sel_e;

    // Glitch filter states for one line.
    typedef enum logic [1:0] {
        FLT_LOW      = 2'd0,
        FLT_RISE_CHK = 2'd1,
        FLT_HIGH     = 2'd2,
        FLT_FALL_CHK = 2'd3
    } flt_state_e;

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int unsigned WIDTH  = 18,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/exti_glitch_filter.sv
module exti_glitch_filter
    import exti_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic lvl_o
);

    localparam int unsigned CNT_W = $clog2(STABLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STABLE_CYC - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
    localparam bit SINGLE = (STABLE_CYC <= 1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic: cnt_q counts the samples already seen at the new level
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            FLT_LOW: begin
                if (in_i) begin
                    if (SINGLE) state_d = FLT_HIGH;
                    else begin
                        state_d = FLT_RISE_CHK;
                        cnt_d   = ONE_CNT;
                    end
                end
            end
            FLT_RISE_CHK: begin
                if (!in_i)                 state_d = FLT_LOW;
                else if (cnt_q == LAST_CNT) state_d = FLT_HIGH;
                else                       cnt_d = cnt_q + ONE_CNT;
            end
            FLT_HIGH: begin
                if (!in_i) begin
                    if (SINGLE) state_d = FLT_LOW;
                    else begin
                        state_d = FLT_FALL_CHK;
                        cnt_d   = ONE_CNT;
                    end
                end
            end
            FLT_FALL_CHK: begin
                if (in_i)                  state_d = FLT_HIGH;
                else if (cnt_q == LAST_CNT) state_d = FLT_LOW;
                else                       cnt_d = cnt_q + ONE_CNT;
            end
            default: begin
                state_d = FLT_LOW;
            end
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            FLT_HIGH, FLT_FALL_CHK: lvl_o = 1'b1;
            default:                lvl_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/exti_edge_detect.sv
module exti_edge_detect #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    output logic [WIDTH-1:0] hit_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    always_comb begin
        for (int i = 0; i < int'(WIDTH); i++) begin
            hit_o[i] = (lvl_i[i] & ~prev_q[i] & rise_en_i[i]) |
                       (~lvl_i[i] & prev_q[i] & fall_en_i[i]);
        end
    end

endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int unsigned WIDTH  = 18,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  hit_i,
    output logic [WIDTH-1:0]  flag_o,
    output logic [WIDTH-1:0]  irq_en_o,
    output logic [WIDTH-1:0]  wake_en_o,
    output logic [WIDTH-1:0]  rise_en_o,
    output logic [WIDTH-1:0]  fall_en_o,
    output logic [WIDTH-1:0]  filt_en_o,
    output logic [WIDTH-1:0]  rdata_o
);

    logic [WIDTH-1:0] flag_q, irq_en_q, wake_en_q, rise_en_q, fall_en_q, filt_en_q;
    logic [WIDTH-1:0] clr_mask, rd_next, rdata_q;

    function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input reg_sel_e r);
        return a == ADDR_W'(r);
    endfunction

    assign clr_mask = (wr_i && hit_addr(addr_i, REG_FLAG)) ? wdata_i : '0;

    // Sticky flags: a new edge outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q  <= '0;
            wake_en_q <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            filt_en_q <= '0;
        end else if (wr_i) begin
            if (hit_addr(addr_i, REG_IRQ_EN))  irq_en_q  <= wdata_i;
            if (hit_addr(addr_i, REG_WAKE_EN)) wake_en_q <= wdata_i;
            if (hit_addr(addr_i, REG_RISE_EN)) rise_en_q <= wdata_i;
            if (hit_addr(addr_i, REG_FALL_EN)) fall_en_q <= wdata_i;
            if (hit_addr(addr_i, REG_FILT_EN)) filt_en_q <= wdata_i;
        end
    end

    always_comb begin
        rd_next = '0;
        if (hit_addr(addr_i, REG_FLAG))    rd_next = flag_q;
        if (hit_addr(addr_i, REG_IRQ_EN))  rd_next = irq_en_q;
        if (hit_addr(addr_i, REG_WAKE_EN)) rd_next = wake_en_q;
        if (hit_addr(addr_i, REG_RISE_EN)) rd_next = rise_en_q;
        if (hit_addr(addr_i, REG_FALL_EN)) rd_next = fall_en_q;
        if (hit_addr(addr_i, REG_FILT_EN)) rd_next = filt_en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_next;
    end

    assign flag_o    = flag_q;
    assign irq_en_o  = irq_en_q;
    assign wake_en_o = wake_en_q;
    assign rise_en_o = rise_en_q;
    assign fall_en_o = fall_en_q;
    assign filt_en_o = filt_en_q;
    assign rdata_o   = rdata_q;

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl #(
    parameter int unsigned NUM_LINES   = 18,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned STABLE_CYC  = 3,
    parameter int unsigned GRP0_W      = 8,
    parameter int unsigned GRP1_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pins_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [NUM_LINES-1:0] bus_wdata_i,
    output logic [NUM_LINES-1:0] bus_rdata_o,
    output logic [2:0]           irq_o,
    output logic                 wake_o
);

    localparam int unsigned NUM_GROUPS = 3;
    localparam int unsigned GRP2_W     = NUM_LINES - GRP0_W - GRP1_W;
    localparam int unsigned GRP_BASE [NUM_GROUPS] = '{0, GRP0_W, GRP0_W + GRP1_W};
    localparam int unsigned GRP_SIZE [NUM_GROUPS] = '{GRP0_W, GRP1_W, GRP2_W};

    logic [NUM_LINES-1:0] sync_lvl, filt_lvl, sel_lvl, edge_hit;
    logic [NUM_LINES-1:0] flag_vec, irq_en, wake_en, rise_en, fall_en, filt_en;
    logic [NUM_LINES-1:0] irq_masked;

    exti_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (sync_lvl)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        exti_glitch_filter #(.STABLE_CYC(STABLE_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (sync_lvl[i]),
            .lvl_o (filt_lvl[i])
        );
        assign sel_lvl[i] = filt_en[i] ? filt_lvl[i] : sync_lvl[i];
    end

    exti_edge_detect #(.WIDTH(NUM_LINES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (sel_lvl),
        .rise_en_i (rise_en),
        .fall_en_i (fall_en),
        .hit_o     (edge_hit)
    );

    exti_regs #(.WIDTH(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .hit_i     (edge_hit),
        .flag_o    (flag_vec),
        .irq_en_o  (irq_en),
        .wake_en_o (wake_en),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en),
        .filt_en_o (filt_en),
        .rdata_o   (bus_rdata_o)
    );

    assign irq_masked = flag_vec & irq_en;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign irq_o[g] = |irq_masked[GRP_BASE[g] +: GRP_SIZE[g]];
    end

    assign wake_o = |(flag_vec & wake_en);

endmodule

// File: rtl/exti_ctrl_chk.sv
module exti_ctrl_chk #(
    parameter int unsigned W  = 18,
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr_i,
    input logic [AW-1:0] bus_addr_i,
    input logic [W-1:0]  bus_wdata_i,
    input logic [W-1:0]  hit,
    input logic [W-1:0]  flags,
    input logic [W-1:0]  ren,
    input logic [W-1:0]  fen,
    input logic [W-1:0]  sync_lvl,
    input logic [W-1:0]  filt_lvl,
    input logic [2:0]    irq_o,
    input logic          wake_o
);

    logic          flag_wr;
    logic [W-1:0]  clr_req;

    assign flag_wr = bus_wr_i && (bus_addr_i == AW'(0));
    assign clr_req = flag_wr ? bus_wdata_i : '0;

    assert_disabled_line_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(ren | fen)) == '0);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (~flags & $past(flags) & ~$past(clr_req)) == '0);

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ((flags & $past(bus_wdata_i & ~hit)) == '0));

    assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (~flags & $past(hit)) == '0);

    assert_irq_falls_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq_o & $past(irq_o)) != 3'b000) |-> $past(bus_wr_i));

    assert_wake_falls_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_o) |-> $past(bus_wr_i));

    assert_filter_follows_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_lvl ^ $past(filt_lvl)) & ((filt_lvl ^ $past(sync_lvl)) |
                                         (filt_lvl ^ $past(sync_lvl, 2)))) == '0);

endmodule

bind exti_ctrl exti_ctrl_chk #(.W(NUM_LINES), .AW(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .hit         (edge_hit),
    .flags       (flag_vec),
    .ren         (rise_en),
    .fen         (fall_en),
    .sync_lvl    (sync_lvl),
    .filt_lvl    (filt_lvl),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/exti_ctrl_tb.sv
module exti_ctrl_tb;

    localparam int N = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [2:0]    addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic [2:0]    irq;
    logic          wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] exp_flag = '0;
    logic [N-1:0] c_ien = '0, c_wen = '0, c_ren = '0, c_fen = '0, c_flt = '0;

    always #5 clk = ~clk;

    exti_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    function automatic logic [2:0] exp_irq(input logic [N-1:0] f, input logic [N-1:0] en);
        logic [2:0] r = '0;
        for (int i = 0; i < N; i++) begin
            if (f[i] && en[i]) begin
                if (i < 8)       r[0] = 1'b1;
                else if (i < 16) r[1] = 1'b1;
                else             r[2] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [N-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        case (a)
            3'd0: exp_flag &= ~d;
            3'd1: c_ien = d;
            3'd2: c_wen = d;
            3'd3: c_ren = d;
            3'd4: c_fen = d;
            3'd5: c_flt = d;
            default: ;
        endcase
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [N-1:0] v);
        rd = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    // Level change held long enough to pass any filter
    task automatic drive_long(input logic [N-1:0] m);
        pins ^= m;
        exp_flag |= m & ((pins & c_ren) | (~pins & c_fen));
        tick(12);
    endtask

    // Pulse of w cycles on the masked lines, then back
    task automatic drive_short(input logic [N-1:0] m, input int w);
        pins ^= m;
        tick(w);
        pins ^= m;
        exp_flag |= m & ~c_flt & (c_ren | c_fen);
        tick(12);
    endtask

    task automatic check_all(input string tag);
        logic [N-1:0] v;
        reg_rd(3'd0, v);
        chk(32'(v), 32'(exp_flag), {tag, " flags R5"});
        chk(32'(irq), 32'(exp_irq(exp_flag, c_ien)), {tag, " irq R8"});
        chk(32'(wake), 32'(|(exp_flag & c_wen)), {tag, " wake R9"});
    endtask

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'h5eed_0412));
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R12 / R11: reset state
        chk(32'(irq), 32'd0, "R12 irq after reset");
        chk(32'(wake), 32'd0, "R12 wake after reset");
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), v);
            chk(32'(v), 32'd0, "R11 reset value");
        end

        // R11: readback of every config register and the unused slots
        for (int a = 1; a < 6; a++) reg_wr(3'(a), N'(32'h2A5A5 + a * 32'h1111));
        for (int a = 1; a < 6; a++) begin
            reg_rd(3'(a), v);
            chk(32'(v), 32'(N'(32'h2A5A5 + a * 32'h1111)), "R11 readback");
        end
        reg_wr(3'd6, '1);
        reg_rd(3'd6, v);
        chk(32'(v), 32'd0, "R11 unused address 6");
        reg_rd(3'd7, v);
        chk(32'(v), 32'd0, "R11 unused address 7");
        for (int a = 1; a < 6; a++) reg_wr(3'(a), '0);
        check_all("R11 no flags");

        // R1: rising only on line 0
        reg_wr(3'd3, N'(1)); reg_wr(3'd1, N'(1));
        drive_long(N'(1));
        check_all("R1 rise sets");
        reg_wr(3'd0, N'(1));
        drive_long(N'(1));
        check_all("R1 fall ignored");

        // R2: falling only on line 9
        reg_wr(3'd3, '0); reg_wr(3'd4, N'(1 << 9)); reg_wr(3'd1, N'(1 << 9));
        drive_long(N'(1 << 9));
        check_all("R2 rise ignored");
        drive_long(N'(1 << 9));
        check_all("R2 fall sets");
        reg_wr(3'd0, '1);

        // R3: both edges on line 16, wake enabled
        reg_wr(3'd3, N'(1 << 16)); reg_wr(3'd4, N'(1 << 16)); reg_wr(3'd2, N'(1 << 16));
        reg_wr(3'd1, N'(1 << 16));
        drive_long(N'(1 << 16));
        check_all("R3 rise");
        reg_wr(3'd0, N'(1 << 16));
        drive_long(N'(1 << 16));
        check_all("R3 fall");
        reg_wr(3'd0, '1);

        // R4: line 17 with both masks clear but irq/wake enabled
        reg_wr(3'd3, '0); reg_wr(3'd4, '0);
        reg_wr(3'd1, N'(1 << 17)); reg_wr(3'd2, N'(1 << 17));
        drive_long(N'(1 << 17));
        drive_short(N'(1 << 17), 1);
        drive_long(N'(1 << 17));
        check_all("R4 disabled line");

        // R6: zero write keeps flags, single 1 clears one bit
        reg_wr(3'd3, '1); reg_wr(3'd4, '1);
        drive_long(N'(32'h00C3));
        reg_wr(3'd0, '0);
        check_all("R6 zero write");
        reg_wr(3'd0, N'(32'h0002));
        check_all("R6 single clear");
        reg_wr(3'd0, '1);

        // R7: edge on line 3 in the cycle the clear is captured
        reg_wr(3'd4, '0); reg_wr(3'd5, '0); reg_wr(3'd3, N'(1 << 3));
        drive_long(N'(1 << 3));          // flag 3 set
        drive_long(N'(1 << 3));          // line back low, no flag change
        pins[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr = 1'b1; addr = 3'd0; wdata = N'(1 << 3);
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        exp_flag[3] = 1'b1;
        tick(6);
        check_all("R7 edge beats clear");
        reg_wr(3'd0, '1);
        check_all("R7 later clear");

        // R10: filter rejects short pulses, bypass sees them
        reg_wr(3'd3, N'(1 << 5)); reg_wr(3'd4, N'(1 << 5)); reg_wr(3'd5, N'(1 << 5));
        drive_short(N'(1 << 5), 1);
        drive_short(N'(1 << 5), 2);
        check_all("R10 filtered short pulses");
        drive_long(N'(1 << 5));
        check_all("R10 filtered long level");
        reg_wr(3'd0, '1);
        drive_long(N'(1 << 5));
        reg_wr(3'd0, '1);
        reg_wr(3'd5, '0);
        drive_short(N'(1 << 5), 1);
        check_all("R10 bypass short pulse");
        reg_wr(3'd0, '1);

        // Random mix across all masks
        for (int it = 0; it < 80; it++) begin
            logic [N-1:0] m;
            reg_wr(3'd1, N'($urandom));
            reg_wr(3'd2, N'($urandom));
            reg_wr(3'd3, N'($urandom));
            reg_wr(3'd4, N'($urandom));
            reg_wr(3'd5, N'($urandom));
            m = N'($urandom);
            if (($urandom % 3) == 0) drive_short(m, 1 + int'($urandom % 2));
            else                     drive_long(m);
            check_all("R1 R2 R3 R10 random");
            reg_wr(3'd0, N'($urandom));
            check_all("R6 random clear");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule